// File: doc/BRIEF.md
# Quadrature Pulse Counter with Programmable Wrap

This block counts pulses arriving on two external lines, channel A and channel B. It counts either single-line edges or quadrature-decoded steps. Both lines are brought into the system clock domain through a synchronizer, and they are edge-detected there. The count runs between zero and a programmable upper bound (`top_i`). Counting past the bound in either direction reloads the counter at the other end and raises a sticky flag.

The block has three counting modes. The meaning of the `edge_inv_i` input depends on the mode:
- In sampled-single mode, `edge_inv_i` picks which edge of channel A is counted.
- In clocked-single mode, only rising edges of channel A are counted, and `edge_inv_i` is ignored.
- In quadrature mode, the direction is derived from the phase of the two lines, and `edge_inv_i` reverses that direction. A separate flag records each reversal of the decoded direction.

All flags feed one interrupt line through per-flag enables. Software finds the cause by reading the flag vector. The block neither sends nor receives any event signals to or from other blocks.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset, `cnt_o` is 0, `flags_o` is 0, `irq_o` is 0, and the stored quadrature direction is up.
- R2: With `mode_i`=0 (sampled single), the counter steps up by one on each rising edge of `ch_a_i` when `edge_inv_i`=0, and on each falling edge when `edge_inv_i`=1. `ch_b_i` has no effect in this mode, and the count never goes down.
- R3: With `mode_i`=1 (clocked single), the counter steps up by one on each rising edge of `ch_a_i`, and the value of `edge_inv_i` has no effect.
- R4: With `mode_i`=2 (quadrature), take the pair {`ch_a_i`,`ch_b_i`}. The moves 00→01, 01→11, 11→10 and 10→00 are up steps, and the reverse moves are down steps. `edge_inv_i`=1 swaps up and down. A move in which both lines change at once is ignored. `mode_i`=3 counts nothing.
- R5: An up step with `cnt_o` equal to `top_i` loads 0 and sets the overflow flag, `flags_o[1]`.
- R6: A down step with `cnt_o` equal to 0 loads `top_i` and sets the underflow flag, `flags_o[0]`.
- R7: In quadrature mode, a valid step whose direction (after inversion) differs from the stored direction sets the direction-change flag, `flags_o[2]`, and stores the new direction. The single modes never set this flag.
- R8: A flag stays set until its bit in `flag_clr_i` is high at a clock edge. If a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq_o` is high exactly when some bit of `flags_o` is set together with the same bit of `irq_en_i`.
- R10: A change on `ch_a_i` or `ch_b_i` reaches `cnt_o` and `flags_o` on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Counting mode: 0 sampled single, 1 clocked single, 2 quadrature |
| edge_inv_i | input | 1 | Edge select (mode 0) or direction invert (mode 2) |
| ch_a_i | input | 1 | Channel A pulse line, asynchronous |
| ch_b_i | input | 1 | Channel B pulse line, asynchronous |
| top_i | input | 16 | Upper wrap bound of the counter |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| flag_clr_i | input | 3 | Per-flag clear strobes |
| cnt_o | output | 16 | Current count |
| flags_o | output | 3 | Sticky flags: bit0 underflow, bit1 overflow, bit2 direction change |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two kinds of internal fault show up differently at the ports:
- A corrupted synchronizer or previous-sample register shows up as a spurious or missing step. `cnt_o` is off by one three edges after the offending line change, and it stays off for every later comparison.
- A wrong stored quadrature direction shows up as a missing or extra `flags_o[2]` on the next valid quadrature step, and so as a wrong `irq_o` when that flag is enabled.

A wrong wrap comparison only becomes visible when the count reaches zero or `top_i`. For that reason the sequences are driven right up to both ends of the range.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    MODE_SAMP_SINGLE = 2'd0,
    MODE_CLK_SINGLE  = 2'd1,
    MODE_QUAD        = 2'd2
  } cnt_mode_e;

  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned FLAG_UNDR = 0;
  localparam int unsigned FLAG_OVR  = 1;
  localparam int unsigned FLAG_DCHG = 2;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cnt_mode_e mode_i,
  input  logic      edge_inv_i,
  input  logic      a_i,
  input  logic      b_i,
  output logic      step_o,
  output logic      down_o,
  output logic      dir_chg_o
);
  logic a_q, b_q, dir_dn_q;
  logic [1:0] pos_prev, pos_cur, pos_diff;
  logic q_valid, q_dn;

  // Gray pair {a,b} -> position 0..3; a forward move is +1 mod 4
  assign pos_prev = {a_q, a_q ^ b_q};
  assign pos_cur  = {a_i, a_i ^ b_i};
  assign pos_diff = pos_cur - pos_prev;
  assign q_valid  = (pos_diff == 2'd1) || (pos_diff == 2'd3);
  assign q_dn     = (pos_diff == 2'd3) ^ edge_inv_i;

  always_comb begin
    step_o    = 1'b0;
    down_o    = 1'b0;
    dir_chg_o = 1'b0;
    unique case (mode_i)
      MODE_SAMP_SINGLE: step_o = edge_inv_i ? (a_q & ~a_i) : (~a_q & a_i);
      MODE_CLK_SINGLE:  step_o = ~a_q & a_i;
      MODE_QUAD: begin
        step_o    = q_valid;
        down_o    = q_dn;
        dir_chg_o = q_valid && (q_dn != dir_dn_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= 1'b0;
      b_q      <= 1'b0;
      dir_dn_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      if (mode_i == MODE_QUAD && q_valid) dir_dn_q <= q_dn;
    end
  end
endmodule

// File: rtl/qpc_count.sv
module qpc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             undr_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic at_top, at_zero;

  assign at_top  = (cnt_q == top_i);
  assign at_zero = (cnt_q == '0);
  assign ovr_o   = step_i & ~down_i & at_top;
  assign undr_o  = step_i &  down_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (step_i) begin
      if (down_i) cnt_q <= at_zero ? top_i : cnt_q - 1'b1;
      else        cnt_q <= at_top  ? '0    : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qpc_flags.sv
module qpc_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              edge_inv_i,
  input  logic              ch_a_i,
  input  logic              ch_b_i,
  input  logic [CNT_W-1:0]  top_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [1:0] lines_s;
  logic step_w, down_w, dchg_w, undr_w, ovr_w;
  logic [FLAG_W-1:0] set_w;
  cnt_mode_e mode_w;

  assign mode_w = cnt_mode_e'(mode_i);

  qpc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i, .rst_ni, .d_i({ch_a_i, ch_b_i}), .q_o(lines_s)
  );

  qpc_decode i_decode (
    .clk_i, .rst_ni, .mode_i(mode_w), .edge_inv_i,
    .a_i(lines_s[1]), .b_i(lines_s[0]),
    .step_o(step_w), .down_o(down_w), .dir_chg_o(dchg_w)
  );

  qpc_count #(.CNT_W(CNT_W)) i_count (
    .clk_i, .rst_ni, .step_i(step_w), .down_i(down_w), .top_i,
    .cnt_o, .undr_o(undr_w), .ovr_o(ovr_w)
  );

  always_comb begin
    set_w            = '0;
    set_w[FLAG_UNDR] = undr_w;
    set_w[FLAG_OVR]  = ovr_w;
    set_w[FLAG_DCHG] = dchg_w;
  end

  qpc_flags #(.N(FLAG_W)) i_flags (
    .clk_i, .rst_ni, .set_i(set_w), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .flags_o, .irq_o
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] top_i,
  input logic [2:0]       flag_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [2:0]       flags_o,
  input logic             step_i,
  input logic             down_i
);
  assert_overflow_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !down_i && cnt_o == top_i) |=> (cnt_o == '0 && flags_o[1]));

  assert_underflow_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && down_i && cnt_o == '0) |=> (cnt_o == $past(top_i) && flags_o[0]));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_o & ~flag_clr_i)) |=>
      ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)));

  assert_single_up_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd2 && step_i) |=>
      (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

  assert_no_dchg_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd2 && !flags_o[2]) |=> !flags_o[2]);

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_o));
endmodule

bind quad_pulse_counter qpc_checker #(.CNT_W(CNT_W)) i_qpc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .top_i(top_i),
  .flag_clr_i(flag_clr_i), .cnt_o(cnt_o), .flags_o(flags_o),
  .step_i(step_w), .down_i(down_w)
);

// File: tb/test_quad_pulse_counter.sv
`timescale 1ns/1ps
module test_quad_pulse_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic inv = 1'b0, ch_a = 1'b0, ch_b = 1'b0;
  logic [15:0] top = 16'd5;
  logic [2:0] irq_en = 3'b000, flag_clr = 3'b000;
  logic [15:0] cnt_o;
  logic [2:0] flags_o;
  logic irq_o;

  always #2.5 clk = ~clk;

  quad_pulse_counter i_quad_pulse_counter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .edge_inv_i(inv),
    .ch_a_i(ch_a), .ch_b_i(ch_b), .top_i(top), .irq_en_i(irq_en),
    .flag_clr_i(flag_clr), .cnt_o(cnt_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  typedef struct packed {logic [15:0] cnt; logic [2:0] flg; logic irq;} exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cnt = '0;
  logic [2:0]  m_flg = '0;
  logic        m_dn = 1'b0, m_a = 1'b0, m_b = 1'b0;

  function automatic logic m_irq();
    return |(m_flg & irq_en);
  endfunction

  task automatic push(string tag);
    exp_q.push_back('{m_cnt, m_flg, m_irq()});
    tag_q.push_back(tag);
    ->chk_ev;
  endtask

  task automatic m_count(bit up);
    if (up) begin
      if (m_cnt == top) begin m_cnt = '0; m_flg[1] = 1'b1; end
      else m_cnt = m_cnt + 16'd1;
    end else begin
      if (m_cnt == 16'd0) begin m_cnt = top; m_flg[0] = 1'b1; end
      else m_cnt = m_cnt - 16'd1;
    end
  endtask

  task automatic m_step(bit a, bit b);
    bit up_raw, dn_raw, d_dn;
    up_raw = 0; dn_raw = 0;
    case (mode)
      2'd0: if ((!inv && !m_a && a) || (inv && m_a && !a)) m_count(1'b1);
      2'd1: if (!m_a && a) m_count(1'b1);
      2'd2: begin
        case ({m_a, m_b, a, b})
          4'b0001, 4'b0111, 4'b1110, 4'b1000: up_raw = 1;
          4'b0100, 4'b1101, 4'b1011, 4'b0010: dn_raw = 1;
          default: ;
        endcase
        if (up_raw || dn_raw) begin
          d_dn = dn_raw ^ inv;
          if (d_dn != m_dn) m_flg[2] = 1'b1;
          m_dn = d_dn;
          m_count(!d_dn);
        end
      end
      default: ;
    endcase
    m_a = a; m_b = b;
  endtask

  // lines change at N0, count lands at the third rising edge, checked after it
  task automatic drive(string tag, bit a, bit b, bit clr_hit = 0, logic [2:0] clrv = 3'b000);
    @(negedge clk); ch_a = a; ch_b = b;
    @(negedge clk);
    @(negedge clk); if (clr_hit) flag_clr = clrv;
    @(negedge clk); flag_clr = 3'b000;
    if (clr_hit) m_flg = m_flg & ~clrv;
    m_step(a, b);
    @(negedge clk);
    push(tag);
  endtask

  task automatic clear_flags(string tag, logic [2:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 3'b000;
    m_flg = m_flg & ~v;
    push(tag);
  endtask

  initial begin
    exp_t e; string t;
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if ({cnt_o, flags_o, irq_o} != e) begin
          n_bad++;
          $display("FAIL %s: got cnt=%0d flags=%b irq=%b, expected cnt=%0d flags=%b irq=%b",
                   t, cnt_o, flags_o, irq_o, e.cnt, e.flg, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset state");

    // sampled single
    drive("R2 rising counted", 1, 0);
    drive("R2 falling ignored", 0, 0);
    drive("R2 ch_b ignored", 0, 1);
    drive("R2 ch_b ignored", 0, 0);
    drive("R2 rising counted", 1, 0);
    @(negedge clk); inv = 1'b1;
    drive("R2 falling counted inv", 0, 0);
    drive("R2 rising ignored inv", 1, 0);

    // clocked single
    @(negedge clk); mode = 2'd1;
    drive("R3 fall ignored", 0, 0);
    drive("R3 rise counted inv=1", 1, 0);
    @(negedge clk); inv = 1'b0;
    drive("R3 fall ignored", 0, 0);
    drive("R3 rise counted inv=0", 1, 0);
    drive("R3 fall ignored", 0, 0);

    // overflow at top
    @(negedge clk); irq_en = 3'b010;
    drive("R5 R9 overflow wrap", 1, 0);
    drive("R8 flag held", 0, 0);
    for (int i = 0; i < 5; i++) begin
      drive("R8 sticky while counting", 1, 0);
      drive("R8 sticky while counting", 0, 0);
    end
    drive("R8 set wins over clear", 1, 0, 1, 3'b010);
    drive("R5 after wrap", 0, 0);
    clear_flags("R8 R9 clear strobe", 3'b010);

    // quadrature
    @(negedge clk); mode = 2'd2; irq_en = 3'b111;
    drive("R4 up 00-01", 0, 1);
    drive("R4 up 01-11", 1, 1);
    drive("R4 up 11-10", 1, 0);
    drive("R4 up 10-00", 0, 0);
    drive("R7 reverse sets dchg", 1, 0);
    drive("R4 down 10-11", 1, 1);
    drive("R4 down 11-01", 0, 1);
    drive("R4 down 01-00", 0, 0);
    drive("R6 underflow reload", 1, 0);
    drive("R4 double move ignored", 0, 1);
    drive("R4 down 01-00", 0, 0);
    clear_flags("R8 clear two flags", 3'b101);
    @(negedge clk); inv = 1'b1;
    drive("R4 inverted up is down", 0, 1);
    drive("R7 inverted reverse", 0, 0);
    @(negedge clk); mode = 2'd3;
    drive("R4 reserved mode idle", 1, 0);
    drive("R4 reserved mode idle", 0, 0);

    // latency
    @(negedge clk); mode = 2'd1;
    @(negedge clk); ch_a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    push("R10 not before third edge");
    @(negedge clk);
    m_step(1, 0);
    push("R10 at third edge");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule